// File: doc/BRIEF.md
# Dual X/Y Prefetch Address Unit

This unit forms the two operand fetch addresses that a dual-operand multiply-accumulate instruction needs in one cycle. One address goes to the X data space and one to the Y data space. Each space has a fixed pair of pointer registers. The X side is served by the first two pointers of a four-register prefetch set, and the Y side by the last two. The decoder supplies the chosen pointer index, its current contents and a 3-bit modify code for each side. It also supplies the shared offset register value and the low and high bounds of both spaces.

The unit registers its results. One cycle after a request it presents both effective addresses and the updated pointer value for each side, with a write enable and the index of the register to update. Two error flags come out with them. One flags an address outside its space. The other flags an illegal pointer or mode choice. Either error cancels every pointer update for that request, so the register file stays as it was.

Top module: `dual_prefetch_agu`

## Requirements
- R1: While rst_ni is low, valid_o, both write enables, err_bounds_o and err_mode_o are 0.
- R2: Pointer index encoding is 0..3 for the four prefetch registers. The X side accepts only index 0 or 1, and the Y side accepts only index 2 or 3. Any other index sets err_mode_o.
- R3: Modify code 3'b000 gives an effective address equal to the pointer contents, with no write-back.
- R4: Modify codes 3'b001, 3'b010 and 3'b011 step the pointer by +2, +4 and +6. Codes 3'b101, 3'b110 and 3'b111 step it by -2, -4 and -6. The effective address is the unmodified pointer, the write-back value is the stepped pointer and the write enable is set.
- R5: Modify code 3'b100 is indexed mode. The effective address is the pointer plus idx_off_i, and the pointer is not written back.
- R6: Indexed mode is legal only on index 1 (X) and index 3 (Y). Indexed mode on index 0 or 2 sets err_mode_o.
- R7: Each effective address must lie inside its space's bounds, inclusive of both ends. For a post-modify code, the stepped value must also lie inside them. Otherwise err_bounds_o is set.
- R8: When either error flag is set, neither write enable is set.
- R9: Results appear one clock after valid_i is sampled high, with valid_o high. A cycle with valid_i low gives valid_o, both write enables and both error flags low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| x_sel_i | input | 2 | X pointer index |
| x_mod_i | input | 3 | X modify code |
| x_ptr_i | input | AW | Contents of the X pointer |
| y_sel_i | input | 2 | Y pointer index |
| y_mod_i | input | 3 | Y modify code |
| y_ptr_i | input | AW | Contents of the Y pointer |
| idx_off_i | input | AW | Offset register value for indexed mode |
| x_lo_i | input | AW | Lowest legal X address |
| x_hi_i | input | AW | Highest legal X address |
| y_lo_i | input | AW | Lowest legal Y address |
| y_hi_i | input | AW | Highest legal Y address |
| valid_o | output | 1 | Results valid |
| x_ea_o | output | AW | X effective address |
| y_ea_o | output | AW | Y effective address |
| x_wb_o | output | AW | New X pointer value |
| x_wb_en_o | output | 1 | X pointer write enable |
| x_wb_sel_o | output | 2 | X pointer index to update |
| y_wb_o | output | AW | New Y pointer value |
| y_wb_en_o | output | 1 | Y pointer write enable |
| y_wb_sel_o | output | 2 | Y pointer index to update |
| err_bounds_o | output | 1 | An address fell outside its space |
| err_mode_o | output | 1 | Illegal pointer or mode request |

## Verification
The bench tests the exact space edges. A pointer stepped onto the top or bottom bound must pass, and one stepped a single step past must fail. A design that checked only the address before modification, or that used strict compares, would get these wrong. Cases where one side is clean and the other is faulty show whether a single error cancels both write-backs. A design that gated each side on its own error would still update the clean pointer. Indexed requests on the non-indexed register of each pair, and pointers steered to the wrong space, must raise the mode flag and leave all pointers untouched. A mid-request reset must clear the outputs at once.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    MOD_NONE = 3'b000,
    MOD_P2   = 3'b001,
    MOD_P4   = 3'b010,
    MOD_P6   = 3'b011,
    MOD_IDX  = 3'b100,
    MOD_M2   = 3'b101,
    MOD_M4   = 3'b110,
    MOD_M6   = 3'b111
  } mod_e;

  localparam int unsigned NLANE = 2;
  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/agu_range_chk.sv
module agu_range_chk #(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] lo_i,
  input  logic [AW-1:0] hi_i,
  output logic          ok_o
);
  assign ok_o = (addr_i >= lo_i) && (addr_i <= hi_i);
endmodule

// File: rtl/agu_lane.sv
module agu_lane
  import agu_pkg::*;
#(
  parameter int unsigned AW      = 16,
  parameter bit          PAIR_HI = 1'b0
) (
  input  logic [SEL_W-1:0] sel_i,
  input  mod_e             mod_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic [AW-1:0]    off_i,
  input  logic [AW-1:0]    lo_i,
  input  logic [AW-1:0]    hi_i,
  output logic [AW-1:0]    ea_o,
  output logic [AW-1:0]    nxt_o,
  output logic             wb_req_o,
  output logic             range_ok_o,
  output logic             mode_ok_o
);
  logic          is_idx;
  logic [AW-1:0] mag;
  logic          ea_ok, nxt_ok;

  assign is_idx   = (mod_i == MOD_IDX);
  assign mag      = {{(AW-3){1'b0}}, mod_i[1:0], 1'b0};
  assign nxt_o    = mod_i[2] ? (ptr_i - mag) : (ptr_i + mag);
  assign ea_o     = is_idx ? (ptr_i + off_i) : ptr_i;
  assign wb_req_o = !is_idx && (mod_i[1:0] != 2'b00);

  agu_range_chk #(.AW(AW)) u_ea_chk (
    .addr_i(ea_o), .lo_i(lo_i), .hi_i(hi_i), .ok_o(ea_ok)
  );
  agu_range_chk #(.AW(AW)) u_nxt_chk (
    .addr_i(nxt_o), .lo_i(lo_i), .hi_i(hi_i), .ok_o(nxt_ok)
  );

  // post-modified value must also stay in space
  assign range_ok_o = ea_ok && (!wb_req_o || nxt_ok);
  // pair selected by index msb; indexed only on odd member
  assign mode_ok_o  = (sel_i[1] == PAIR_HI) && (!is_idx || sel_i[0]);
endmodule

// File: rtl/dual_prefetch_agu.sv
module dual_prefetch_agu
  import agu_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    x_sel_i,
  input  logic [2:0]    x_mod_i,
  input  logic [AW-1:0] x_ptr_i,
  input  logic [1:0]    y_sel_i,
  input  logic [2:0]    y_mod_i,
  input  logic [AW-1:0] y_ptr_i,
  input  logic [AW-1:0] idx_off_i,
  input  logic [AW-1:0] x_lo_i,
  input  logic [AW-1:0] x_hi_i,
  input  logic [AW-1:0] y_lo_i,
  input  logic [AW-1:0] y_hi_i,
  output logic          valid_o,
  output logic [AW-1:0] x_ea_o,
  output logic [AW-1:0] y_ea_o,
  output logic [AW-1:0] x_wb_o,
  output logic          x_wb_en_o,
  output logic [1:0]    x_wb_sel_o,
  output logic [AW-1:0] y_wb_o,
  output logic          y_wb_en_o,
  output logic [1:0]    y_wb_sel_o,
  output logic          err_bounds_o,
  output logic          err_mode_o
);
  logic [SEL_W-1:0] sel_a  [NLANE];
  mod_e             mod_a  [NLANE];
  logic [AW-1:0]    ptr_a  [NLANE];
  logic [AW-1:0]    lo_a   [NLANE];
  logic [AW-1:0]    hi_a   [NLANE];
  logic [AW-1:0]    ea_a   [NLANE];
  logic [AW-1:0]    nxt_a  [NLANE];
  logic [NLANE-1:0] wbr_a, rok_a, mok_a;

  assign sel_a[0] = x_sel_i;       assign sel_a[1] = y_sel_i;
  assign mod_a[0] = mod_e'(x_mod_i); assign mod_a[1] = mod_e'(y_mod_i);
  assign ptr_a[0] = x_ptr_i;       assign ptr_a[1] = y_ptr_i;
  assign lo_a[0]  = x_lo_i;        assign lo_a[1]  = y_lo_i;
  assign hi_a[0]  = x_hi_i;        assign hi_a[1]  = y_hi_i;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    agu_lane #(.AW(AW), .PAIR_HI(g != 0)) u_lane (
      .sel_i(sel_a[g]), .mod_i(mod_a[g]), .ptr_i(ptr_a[g]), .off_i(idx_off_i),
      .lo_i(lo_a[g]), .hi_i(hi_a[g]), .ea_o(ea_a[g]), .nxt_o(nxt_a[g]),
      .wb_req_o(wbr_a[g]), .range_ok_o(rok_a[g]), .mode_ok_o(mok_a[g])
    );
  end

  logic all_ok;
  assign all_ok = (&rok_a) && (&mok_a);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      x_ea_o       <= '0;
      y_ea_o       <= '0;
      x_wb_o       <= '0;
      y_wb_o       <= '0;
      x_wb_sel_o   <= '0;
      y_wb_sel_o   <= '0;
      x_wb_en_o    <= 1'b0;
      y_wb_en_o    <= 1'b0;
      err_bounds_o <= 1'b0;
      err_mode_o   <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      x_wb_en_o    <= valid_i && wbr_a[0] && all_ok;
      y_wb_en_o    <= valid_i && wbr_a[1] && all_ok;
      err_bounds_o <= valid_i && !(&rok_a);
      err_mode_o   <= valid_i && !(&mok_a);
      if (valid_i) begin
        x_ea_o     <= ea_a[0];
        y_ea_o     <= ea_a[1];
        x_wb_o     <= nxt_a[0];
        y_wb_o     <= nxt_a[1];
        x_wb_sel_o <= x_sel_i;
        y_wb_sel_o <= y_sel_i;
      end
    end
  end

  assert_mode_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (x_sel_i[1] || !y_sel_i[1]) |=> err_mode_o);
  assert_wb_moves_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    x_wb_en_o |-> (x_wb_o != x_ea_o));
  assert_idx_nowb_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (x_mod_i == 3'b100) |=> !x_wb_en_o);
  assert_idx_w8_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (x_mod_i == 3'b100) && (x_sel_i == 2'd0) |=> err_mode_o);
  assert_err_blocks_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_bounds_o || err_mode_o) |-> (!x_wb_en_o && !y_wb_en_o));
  assert_valid_lat_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !x_wb_en_o && !y_wb_en_o && !err_bounds_o));
endmodule

// File: tb/tb_dual_prefetch_agu.sv
module tb_dual_prefetch_agu;
  localparam int unsigned AW = 16;
  localparam int unsigned NV = 13;

  typedef struct packed {
    logic [1:0]  xs; logic [2:0] xm; logic [15:0] xp;
    logic [1:0]  ys; logic [2:0] ym; logic [15:0] yp;
    logic [15:0] off;
    logic [15:0] xea; logic [15:0] yea;
    logic        xwe; logic [15:0] xwb;
    logic        ywe; logic [15:0] ywb;
    logic        eb;  logic        em;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{2'd0,3'b000,16'h0800, 2'd2,3'b000,16'h1000, 16'h0000, 16'h0800,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
    '{2'd0,3'b001,16'h0800, 2'd3,3'b101,16'h1010, 16'h0000, 16'h0800,16'h1010, 1'b1,16'h0802, 1'b1,16'h100E, 1'b0,1'b0},
    '{2'd1,3'b011,16'h0900, 2'd2,3'b111,16'h1100, 16'h0000, 16'h0900,16'h1100, 1'b1,16'h0906, 1'b1,16'h10FA, 1'b0,1'b0},
    '{2'd1,3'b010,16'h0A00, 2'd3,3'b110,16'h1200, 16'h0000, 16'h0A00,16'h1200, 1'b1,16'h0A04, 1'b1,16'h11FC, 1'b0,1'b0},
    '{2'd1,3'b100,16'h0800, 2'd3,3'b100,16'h1000, 16'h0010, 16'h0810,16'h1010, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b0},
    '{2'd0,3'b100,16'h0800, 2'd2,3'b000,16'h1000, 16'h0000, 16'h0800,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b1},
    '{2'd2,3'b001,16'h0800, 2'd3,3'b001,16'h1000, 16'h0000, 16'h0800,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b1},
    '{2'd0,3'b001,16'h0FFE, 2'd2,3'b001,16'h1000, 16'h0000, 16'h0FFE,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
    '{2'd0,3'b101,16'h0800, 2'd2,3'b001,16'h1000, 16'h0000, 16'h0800,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
    '{2'd0,3'b011,16'h0FF9, 2'd3,3'b101,16'h1002, 16'h0000, 16'h0FF9,16'h1002, 1'b1,16'h0FFF, 1'b1,16'h1000, 1'b0,1'b0},
    '{2'd0,3'b001,16'h0800, 2'd2,3'b000,16'h1800, 16'h0000, 16'h0800,16'h1800, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
    '{2'd1,3'b100,16'h0FF0, 2'd3,3'b000,16'h1000, 16'h0010, 16'h1000,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b1,1'b0},
    '{2'd0,3'b000,16'h0800, 2'd2,3'b100,16'h1000, 16'h0000, 16'h0800,16'h1000, 1'b0,16'h0000, 1'b0,16'h0000, 1'b0,1'b1}
  };

  function automatic string tag(input int i);
    case (i)
      0: return "R3";
      1, 2, 3: return "R4";
      4: return "R5";
      5, 12: return "R6";
      6: return "R2";
      10: return "R8";
      default: return "R7";
    endcase
  endfunction

  logic clk = 1'b0, rst_ni = 1'b0, valid_i = 1'b0;
  logic [1:0] x_sel_i = '0, y_sel_i = '0, x_wb_sel_o, y_wb_sel_o;
  logic [2:0] x_mod_i = '0, y_mod_i = '0;
  logic [AW-1:0] x_ptr_i = '0, y_ptr_i = '0, idx_off_i = '0;
  logic [AW-1:0] x_lo_i = 16'h0800, x_hi_i = 16'h0FFF, y_lo_i = 16'h1000, y_hi_i = 16'h17FF;
  logic valid_o, x_wb_en_o, y_wb_en_o, err_bounds_o, err_mode_o;
  logic [AW-1:0] x_ea_o, y_ea_o, x_wb_o, y_wb_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_prefetch_agu #(.AW(AW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_sel_i(x_sel_i), .x_mod_i(x_mod_i), .x_ptr_i(x_ptr_i),
    .y_sel_i(y_sel_i), .y_mod_i(y_mod_i), .y_ptr_i(y_ptr_i),
    .idx_off_i(idx_off_i), .x_lo_i(x_lo_i), .x_hi_i(x_hi_i),
    .y_lo_i(y_lo_i), .y_hi_i(y_hi_i), .valid_o(valid_o),
    .x_ea_o(x_ea_o), .y_ea_o(y_ea_o), .x_wb_o(x_wb_o), .x_wb_en_o(x_wb_en_o),
    .x_wb_sel_o(x_wb_sel_o), .y_wb_o(y_wb_o), .y_wb_en_o(y_wb_en_o),
    .y_wb_sel_o(y_wb_sel_o), .err_bounds_o(err_bounds_o), .err_mode_o(err_mode_o)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    valid_i = 1'b1;
    x_sel_i = v.xs; x_mod_i = v.xm; x_ptr_i = v.xp;
    y_sel_i = v.ys; y_mod_i = v.ym; y_ptr_i = v.yp;
    idx_off_i = v.off;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 1'b0, 1'b1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "valid_o", 16'(valid_o), 16'h0);
    chk("R1", "wb_en", 16'({x_wb_en_o, y_wb_en_o}), 16'h0);
    chk("R1", "errs", 16'({err_bounds_o, err_mode_o}), 16'h0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      chk(tag(i), "valid_o R9", 16'(valid_o), 16'h1);
      chk(tag(i), "x_ea", x_ea_o, VEC[i].xea);
      chk(tag(i), "y_ea", y_ea_o, VEC[i].yea);
      chk(tag(i), "x_wb_en", 16'(x_wb_en_o), 16'(VEC[i].xwe));
      chk(tag(i), "y_wb_en", 16'(y_wb_en_o), 16'(VEC[i].ywe));
      if (VEC[i].xwe) begin
        chk(tag(i), "x_wb", x_wb_o, VEC[i].xwb);
        chk(tag(i), "x_wb_sel", 16'(x_wb_sel_o), 16'(VEC[i].xs));
      end
      if (VEC[i].ywe) begin
        chk(tag(i), "y_wb", y_wb_o, VEC[i].ywb);
        chk(tag(i), "y_wb_sel", 16'(y_wb_sel_o), 16'(VEC[i].ys));
      end
      chk(tag(i), "err_bounds", 16'(err_bounds_o), 16'(VEC[i].eb));
      chk(tag(i), "err_mode", 16'(err_mode_o), 16'(VEC[i].em));
    end

    // R9: idle cycle with a write-back pattern on the inputs
    @(negedge clk);
    drive(VEC[1]);
    valid_i = 1'b0;
    @(negedge clk);
    chk("R9", "idle valid_o", 16'(valid_o), 16'h0);
    chk("R9", "idle wb_en", 16'({x_wb_en_o, y_wb_en_o}), 16'h0);
    chk("R9", "idle errs", 16'({err_bounds_o, err_mode_o}), 16'h0);

    // R1: asynchronous reset clears a live result
    drive(VEC[2]);
    @(negedge clk);
    chk("R1", "pre-reset wb_en", 16'(x_wb_en_o), 16'h1);
    valid_i = 1'b0;
    #2 rst_ni = 1'b0;
    #1;
    chk("R1", "async valid_o", 16'(valid_o), 16'h0);
    chk("R1", "async wb_en", 16'({x_wb_en_o, y_wb_en_o}), 16'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    // R8: clean X step with a Y mode fault still blocks the X update
    @(negedge clk);
    drive(VEC[1]);
    y_sel_i = 2'd1;
    @(negedge clk);
    chk("R8", "x_wb_en on y fault", 16'(x_wb_en_o), 16'h0);
    chk("R2", "y in x pair", 16'(err_mode_o), 16'h1);
    valid_i = 1'b0;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule